// File: doc/BRIEF.md
# Parallel NOR Flash Read Front End

This block sits between the pins of a parallel NOR flash model and its storage array and decides what the data bus shows during reads. It takes active-low chip-enable, output-enable and byte-select pins, an address bus and a command code from an external command decoder. It drives a 16-bit data bus together with a separate output-enable bit for each lane, so the pads can be modelled as tristates. Array data comes from a synchronous memory with one cycle of latency. The output enables pass through the same pipeline stage, so data and enables line up. When byte-select is low, data pin 15 stops acting as an output and is sampled as the half-word select below address bit 0.

A small mode machine tracks what a read returns. In `MODE_ARRAY`, reads return array data. In `MODE_SUSPEND`, reads from sectors flagged in a per-sector mask return the status word and all other sectors return array data. In `MODE_LOCKED`, every read returns the status word. The transitions are:
- `MODE_ARRAY -> MODE_SUSPEND` on the suspend command.
- `MODE_SUSPEND -> MODE_ARRAY` on the done or reset command.
- any mode `-> MODE_LOCKED` on the lock command, which the decoder issues for an error flag or for identification.
- `MODE_LOCKED -> MODE_ARRAY` on the reset command only.

The pin reset returns the machine to `MODE_ARRAY`.

A sleep timer watches the access key: address, half-word select, chip-enable and byte-select. Once the key has been unchanged for a parameter number of cycles, the block stops issuing memory reads and holds the last data. Any change of the key wakes it and fetches fresh data.

Top module: `flash_rd_front`

## Requirements
- R1: With byte_n=1 and both ce_n and oe_n low, after the next clock edge dq_oe is 16'hFFFF and dq_out holds the full array word at addr.
- R2: With byte_n=0 and both ce_n and oe_n low, dq_oe is 16'h00FF and dq_out[15:8] is 0. dq_out[7:0] is the low byte of the word when dq15_in=0 and the high byte when dq15_in=1.
- R3: When ce_n is high, dq_oe is 0 after the next edge, whatever the value of oe_n.
- R4: When oe_n is high, dq_oe is 0 after the next edge.
- R5: After the access key has stayed unchanged for SLEEP_CYC clock edges following the edge that captured it, asleep is 1, mem_re is 0 and dq_out holds its value.
- R6: A change of the access key clears asleep at the next edge, and the word at the new address appears on dq_out at that edge.
- R7: After the pin reset, asleep is 0, dq_oe is 0, and reads return array data without any command.
- R8: Command codes are: 0 none, 1 suspend, 2 done, 3 lock, 4 reset; codes 5 to 7 act as none. In suspend mode, a read whose sector (the top $clog2(NSECT) address bits) has its bit set in susp_mask returns status_word, and any other read returns array data.
- R9: The done command returns suspend mode to array reads.
- R10: After the lock command, every read returns status_word. The done command leaves it that way, and only the reset command returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low pin reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| byte_n | input | 1 | Low selects 8-bit bus width |
| addr | input | AW | Word address |
| dq15_in | input | 1 | Half-word select, used in byte mode |
| cmd | input | 3 | Command code from the decoder |
| susp_mask | input | NSECT | One bit per erase-suspended sector |
| status_word | input | 16 | Status data for non-array reads |
| mem_addr | output | AW | Address to the synchronous array |
| mem_re | output | 1 | Array read strobe |
| mem_rdata | input | 16 | Array data, one cycle after mem_re |
| dq_out | output | 16 | Data bus value |
| dq_oe | output | 16 | Per-lane output enable |
| asleep | output | 1 | Automatic sleep active |

## Verification
The bench uses AW=12, NSECT=8, a 70 ns access time and a 10 ns clock, so SLEEP_CYC is 10. At that size, entering and leaving sleep can be checked edge by edge within a few cycles. With eight sectors, the sector field is addr[11:9], so one suspended sector can be placed beside unsuspended neighbours.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'd0,
        MODE_SUSPEND = 2'd1,
        MODE_LOCKED  = 2'd2
    } mode_t;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_SUSPEND = 3'd1,
        CMD_DONE    = 3'd2,
        CMD_LOCK    = 3'd3,
        CMD_RESET   = 3'd4
    } cmd_t;

endpackage

// File: rtl/flash_rd_mode_fsm.sv
module flash_rd_mode_fsm
    import flash_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_code,
    output mode_t      mode
);

    mode_t state_q;
    mode_t state_d;
    cmd_t  cmd_c;

    assign cmd_c = cmd_t'(cmd_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_ARRAY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_ARRAY: begin
                if (cmd_c == CMD_LOCK)         state_d = MODE_LOCKED;
                else if (cmd_c == CMD_SUSPEND) state_d = MODE_SUSPEND;
            end
            MODE_SUSPEND: begin
                if (cmd_c == CMD_LOCK)                               state_d = MODE_LOCKED;
                else if (cmd_c == CMD_DONE || cmd_c == CMD_RESET)    state_d = MODE_ARRAY;
            end
            MODE_LOCKED: begin
                if (cmd_c == CMD_RESET) state_d = MODE_ARRAY;
            end
            default: state_d = MODE_ARRAY;
        endcase
    end

    assign mode = state_q;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOCKED && cmd_code != 3'd4) |=> (state_q == MODE_LOCKED)); // R10

    AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'd4) |=> (state_q == MODE_ARRAY)); // R10

endmodule

// File: rtl/flash_rd_sleep_timer.sv
module flash_rd_sleep_timer #(
    parameter int KEY_W     = 15,
    parameter int SLEEP_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    output logic             changed,
    output logic             asleep
);

    localparam int CNT_W = $clog2(SLEEP_CYC + 1);

    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] cnt_q;

    assign changed = (key != key_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            cnt_q  <= '0;
            asleep <= 1'b0;
        end else if (changed) begin
            key_q  <= key;
            cnt_q  <= '0;
            asleep <= 1'b0;
        end else if (cnt_q == CNT_W'(SLEEP_CYC - 1)) begin
            asleep <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WAKE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> !asleep); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (cnt_q <= CNT_W'(SLEEP_CYC - 1))); // R5

endmodule

// File: rtl/flash_rd_lane_steer.sv
module flash_rd_lane_steer #(
    parameter int DW = 16
) (
    input  logic          drive_en,
    input  logic          byte_mode,
    input  logic          hi_half,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe
);

    localparam int HW = DW / 2;

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (drive_en) begin
            if (byte_mode) begin
                dq_out[HW-1:0] = hi_half ? word[DW-1:HW] : word[HW-1:0];
                dq_oe[HW-1:0]  = '1;
            end else begin
                dq_out = word;
                dq_oe  = '1;
            end
        end
    end

endmodule

// File: rtl/flash_rd_front.sv
module flash_rd_front
    import flash_rd_pkg::*;
#(
    parameter int AW        = 12,
    parameter int NSECT     = 8,
    parameter int ACCESS_NS = 70,
    parameter int CLK_NS    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             byte_n,
    input  logic [AW-1:0]    addr,
    input  logic             dq15_in,
    input  logic [2:0]       cmd,
    input  logic [NSECT-1:0] susp_mask,
    input  logic [15:0]      status_word,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_re,
    input  logic [15:0]      mem_rdata,
    output logic [15:0]      dq_out,
    output logic [15:0]      dq_oe,
    output logic             asleep
);

    localparam int SECT_W    = (NSECT > 1) ? $clog2(NSECT) : 1;
    localparam int SLEEP_CYC = (ACCESS_NS + 30 + CLK_NS - 1) / CLK_NS;
    localparam int KEY_W     = AW + 3;

    mode_t            mode;
    logic             half_sel;
    logic [KEY_W-1:0] key;
    logic             changed;
    logic [SECT_W-1:0] sector;
    logic             want_status;

    logic             p_en, p_byte, p_hi, p_stat_sel;
    logic [15:0]      p_stat;
    logic [15:0]      word_sel;

    flash_rd_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_code (cmd),
        .mode     (mode)
    );

    assign half_sel = byte_n ? 1'b0 : dq15_in;
    assign key      = {ce_n, byte_n, half_sel, addr};

    flash_rd_sleep_timer #(
        .KEY_W     (KEY_W),
        .SLEEP_CYC (SLEEP_CYC)
    ) u_sleep (
        .clk     (clk),
        .rst_n   (rst_n),
        .key     (key),
        .changed (changed),
        .asleep  (asleep)
    );

    generate
        if (NSECT > 1) begin : g_sect
            assign sector = addr[AW-1 -: SECT_W];
        end else begin : g_one
            assign sector = '0;
        end
    endgenerate

    always_comb begin
        want_status = 1'b0;
        unique case (mode)
            MODE_ARRAY:   want_status = 1'b0;
            MODE_SUSPEND: want_status = susp_mask[sector];
            MODE_LOCKED:  want_status = 1'b1;
            default:      want_status = 1'b0;
        endcase
    end

    assign mem_addr = addr;
    assign mem_re   = ~ce_n & (changed | ~asleep);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_en       <= 1'b0;
            p_byte     <= 1'b0;
            p_hi       <= 1'b0;
            p_stat_sel <= 1'b0;
            p_stat     <= '0;
        end else begin
            p_en       <= ~ce_n & ~oe_n;
            p_byte     <= ~byte_n;
            p_hi       <= half_sel;
            p_stat_sel <= want_status;
            p_stat     <= status_word;
        end
    end

    assign word_sel = p_stat_sel ? p_stat : mem_rdata;

    flash_rd_lane_steer #(.DW(16)) u_steer (
        .drive_en  (p_en),
        .byte_mode (p_byte),
        .hi_half   (p_hi),
        .word      (word_sel),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dq_oe == 16'h0000)); // R3

    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 16'h0000)); // R4

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !byte_n) |=> (dq_oe == 16'h00FF && dq_out[15:8] == 8'h00)); // R2

    AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && byte_n) |=> (dq_oe == 16'hFFFF)); // R1

endmodule

// File: tb/flash_rd_front_tb.sv
module flash_rd_front_tb;

    localparam int AW = 12;
    localparam int NSECT = 8;
    localparam int SLEEP = 10;

    typedef struct {
        logic [15:0] oe;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1, dq15_in = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0] cmd = 3'd0;
    logic [NSECT-1:0] susp_mask = '0;
    logic [15:0] status_word = 16'h0000;
    logic [AW-1:0] mem_addr;
    logic mem_re;
    logic [15:0] mem_rdata = '0;
    logic [15:0] dq_out, dq_oe;
    logic asleep;

    int checks = 0;
    int fails = 0;
    int tb_mode = 0;   // 0 array, 1 suspend, 2 locked
    exp_t exp_q[$];

    always #5 clk = ~clk;

    flash_rd_front #(.AW(AW), .NSECT(NSECT), .ACCESS_NS(70), .CLK_NS(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .byte_n(byte_n),
        .addr(addr), .dq15_in(dq15_in), .cmd(cmd), .susp_mask(susp_mask),
        .status_word(status_word), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .dq_out(dq_out), .dq_oe(dq_oe), .asleep(asleep)
    );

    function automatic logic [15:0] arr_word(input logic [AW-1:0] a);
        logic [15:0] t;
        t = {4'h0, a} * 16'h9E37;
        return t ^ 16'hC3A5;
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= arr_word(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic c, input logic o, input logic bn, input logic hi,
                      input logic [AW-1:0] a, input string req);
        exp_t e;
        logic [15:0] w;
        logic st;
        @(negedge clk);
        ce_n = c; oe_n = o; byte_n = bn; dq15_in = hi; addr = a;
        st = (tb_mode == 2) || (tb_mode == 1 && susp_mask[a[AW-1:AW-3]]);
        w = st ? status_word : arr_word(a);
        if (!c && !o) begin
            if (bn) begin e.oe = 16'hFFFF; e.data = w; end
            else begin e.oe = 16'h00FF; e.data = {8'h00, hi ? w[15:8] : w[7:0]}; end
        end else begin
            e.oe = 16'h0000; e.data = 16'h0000;
        end
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic pulse(input logic [2:0] c);
        @(negedge clk);
        cmd = c;
        if (c == 3'd1 && tb_mode == 0) tb_mode = 1;
        else if (c == 3'd2 && tb_mode == 1) tb_mode = 0;
        else if (c == 3'd3) tb_mode = 2;
        else if (c == 3'd4) tb_mode = 0;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " lanes"}, {16'h0, dq_oe}, {16'h0, e.oe});
                check({e.req, " data"}, {16'h0, dq_out}, {16'h0, e.data});
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        check("R7 reset lanes", {16'h0, dq_oe}, 32'h0);
        check("R7 reset sleep", {31'h0, asleep}, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R7 and R1: array read with no command
        rd(0, 0, 1, 0, 12'h123, "R7");
        rd(0, 0, 1, 0, 12'h7FE, "R1");
        rd(0, 0, 1, 0, 12'hFFF, "R1");
        rd(0, 0, 1, 1, 12'h001, "R1");
        // R2 byte lanes
        rd(0, 0, 0, 0, 12'h2A5, "R2");
        rd(0, 0, 0, 1, 12'h2A5, "R2");
        rd(0, 0, 0, 1, 12'h9C3, "R2");
        // R3 standby, R4 output disable
        rd(1, 0, 1, 0, 12'h050, "R3");
        rd(1, 1, 0, 0, 12'h051, "R3");
        rd(0, 1, 1, 0, 12'h052, "R4");
        rd(0, 0, 1, 0, 12'h053, "R1");

        // R8 suspend with sector 2 (addr[11:9]=2) flagged
        susp_mask = 8'b0000_0100;
        status_word = 16'h5AC3;
        pulse(3'd1);
        rd(0, 0, 1, 0, 12'h420, "R8");
        rd(0, 0, 1, 0, 12'h010, "R8");
        rd(0, 0, 0, 1, 12'h5F0, "R8");
        rd(0, 0, 1, 0, 12'h600, "R8");
        // R9 done returns to array
        pulse(3'd2);
        rd(0, 0, 1, 0, 12'h420, "R9");
        // R10 lock, done ignored, reset exits
        status_word = 16'h0F20;
        pulse(3'd3);
        rd(0, 0, 1, 0, 12'h010, "R10");
        pulse(3'd2);
        rd(0, 0, 1, 0, 12'h888, "R10");
        pulse(3'd7);
        rd(0, 0, 0, 0, 12'h889, "R10");
        pulse(3'd4);
        rd(0, 0, 1, 0, 12'h010, "R10");

        // R5/R6 sleep entry and exit
        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        ce_n = 0; oe_n = 0; byte_n = 1; dq15_in = 0; addr = 12'h3C7;
        for (int k = 1; k <= SLEEP + 3; k++) begin
            @(posedge clk);
            #2;
            check("R5 asleep", {31'h0, asleep}, {31'h0, (k >= SLEEP + 1)});
            check("R5 hold", {16'h0, dq_out}, {16'h0, arr_word(12'h3C7)});
            if (k >= SLEEP + 1) check("R5 no read", {31'h0, mem_re}, 32'h0);
        end
        @(negedge clk) addr = 12'h3C8;
        @(posedge clk);
        #2;
        check("R6 wake", {31'h0, asleep}, 32'h0);
        check("R6 fresh", {16'h0, dq_out}, {16'h0, arr_word(12'h3C8)});

        // R7 pin reset from locked mode
        pulse(3'd3);
        @(negedge clk) rst_n = 1'b0;
        tb_mode = 0;
        @(negedge clk);
        check("R7 reset lanes", {16'h0, dq_oe}, 32'h0);
        rst_n = 1'b1;
        rd(0, 0, 1, 0, 12'h700, "R7");
        rd(1, 1, 1, 0, 12'h700, "R3");
        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule